// File: doc/BRIEF.md
# Width-Adaptive Card Data Stager

This block sits between a 32-bit register-bus slave and a byte-serial card data path. It holds two 32-byte queues, one per direction. Bus accesses to the data port may be 1, 2 or 4 bytes wide. A write unpacks the bus word byte by byte into the transmit queue. A read packs bytes from the receive queue into the bus word. In both cases the earliest byte sits in the most significant lane of the access.

A transfer begins with a start pulse. The pulse loads a byte counter with the product of a 16-bit block count and a 12-bit block length, and it latches the direction. While the counter is nonzero, bytes move over a valid/ready handshake toward the card (transmit) or from the card (receive), at most one byte per clock. Each byte moved decrements the counter. When the counter reaches zero the transfer goes idle and raises a sticky data-done flag. A transmit transfer also raises a programming-done flag. A partial-flush write discards whatever is queued for transmit. A clock-stop pulse halts the transfer and leaves the queues and the counter untouched.

Top module: `card_data_stager`

## Requirements
- R1: After reset, active, rx_req, tx_req, data_done and prog_done are 0, both queue levels are 0, bytes_left is 0 and rd_data is 0.
- R2: A xfer_start pulse loads bytes_left with blk_cnt*blk_len, sets active and clears data_done and prog_done. If the product is 0, the block goes idle and sets data_done two cycles after the pulse.
- R3: The receive queue never holds more than 32 bytes. card_rx_ready is 0 whenever 32 bytes are queued.
- R4: In receive mode (xfer_dir=0), card_rx_ready is 1 while active, bytes_left is nonzero and the queue has room. Each accepted byte is queued, decrements bytes_left and sets rx_req.
- R5: A data-port read (acc_sel=0, acc_write=0) of width N bytes (acc_width 0→1, 1→2, 2 or 3→4) pops up to N bytes and returns them on rd_data one cycle later. The first byte popped is in lane N-1 (bits 8N-1:8N-8) and later bytes go to lower lanes. The read stops early when the queue empties, and unfilled lanes and lanes at or above N read as 0. The read clears rx_req.
- R6: A data-port write (acc_sel=0, acc_write=1) of width N queues lane N-1 of acc_wdata first, then lower lanes. It queues no bytes beyond 32, and the excess is dropped.
- R7: In transmit mode (xfer_dir=1), card_tx_valid is 1 with the oldest queued byte on card_tx_data while active, bytes_left is nonzero and the queue is non-empty. Each accepted byte decrements bytes_left. tx_req is set while active with bytes_left nonzero and an empty transmit queue. A data-port write clears tx_req.
- R8: One cycle after bytes_left reaches 0 while active, active falls and data_done is set. prog_done is set as well only for a transmit transfer.
- R9: A write to the partial-flush register (acc_sel=1) with acc_wdata[0]=1 empties the transmit queue. With acc_wdata[0]=0 it has no effect.
- R10: A clk_stop pulse clears active and leaves both queue levels and bytes_left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start pulse: load counter, clear queues |
| xfer_dir | input | 1 | Direction latched at start, 1 = transmit to card |
| blk_len | input | 12 | Block length in bytes |
| blk_cnt | input | 16 | Number of blocks |
| clk_stop | input | 1 | Abort pulse |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = data port, 1 = partial-flush register |
| acc_width | input | 2 | Access width code (0:1, 1:2, 2/3:4 bytes) |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Packed read data, valid the cycle after a read |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ready | output | 1 | Block accepts a received byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| active | output | 1 | Transfer in progress |
| bytes_left | output | 28 | Remaining byte count |
| rx_level | output | 6 | Bytes in receive queue |
| tx_level | output | 6 | Bytes in transmit queue |
| rx_req | output | 1 | Receive data request |
| tx_req | output | 1 | Transmit data request |
| data_done | output | 1 | Sticky data-done flag |
| prog_done | output | 1 | Sticky programming-done flag |

## Verification
The assertions check on every cycle the properties that need no scenario: the queue bound, the ban on popping more than is queued, card_rx_ready staying low on a full queue, the counter holding at zero, idleness once data_done rises, prog_done never appearing without data_done, and a clock stop always idling the block. Only the bench scenarios can show lane placement for each access width, the zero fill on a short read, the byte order seen by the card, the dropping of bytes past 32, the effect of the flush bit, and the exact counter values after a start and after an abort.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int BUS_LANES = 4;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_width_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      ACC_BYTE: width_bytes = 3'd1;
      ACC_HALF: width_bytes = 3'd2;
      default:  width_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cds_byte_fifo.sv
module cds_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [LW-1:0]      push_cnt,
  input  logic [8*LANES-1:0] push_data,
  input  logic [LW-1:0]      pop_cnt,
  output logic [PW:0]        level,
  output logic [8*LANES-1:0] peek
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [PW:0]   level_n;

  always_comb begin
    if (clear) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      level_n  = '0;
    end else begin
      wr_ptr_n = wr_ptr + PW'(push_cnt);
      rd_ptr_n = rd_ptr + PW'(pop_cnt);
      level_n  = level + (PW+1)'(push_cnt) - (PW+1)'(pop_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (LW'(i) < push_cnt) mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek[8*g +: 8] = mem[rd_ptr + PW'(g)];
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (PW+1)'(DEPTH));
  p_pop_within_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (PW+1)'(pop_cnt) <= level);
endmodule

// File: rtl/cds_byte_counter.sv
module cds_byte_counter #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] left,
  output logic          zero
);
  logic [CW-1:0] left_n;

  assign zero = (left == '0);

  always_comb begin
    left_n = left;
    if (load)             left_n = load_val;
    else if (dec && !zero) left_n = left - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else        left <= left_n;
  end

  p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/card_data_stager.sv
module card_data_stager #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int CW = LEN_W + CNT_W,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             clk_stop,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_sel,
  input  logic [1:0]       acc_width,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      rd_data,
  input  logic             card_rx_valid,
  input  logic [7:0]       card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [7:0]       card_tx_data,
  input  logic             card_tx_ready,
  output logic             active,
  output logic [CW-1:0]    bytes_left,
  output logic [PW:0]      rx_level,
  output logic [PW:0]      tx_level,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done
);
  import cds_pkg::*;

  localparam int LW = $clog2(BUS_LANES) + 1;

  logic          dir_q, dir_n, active_n;
  logic          rx_req_n, tx_req_n, data_done_n, prog_done_n;
  logic          cnt_zero, finish;
  logic          rx_rd, tx_wr, flush, rx_fire, tx_fire;
  logic [2:0]    nbytes;
  logic [PW:0]   nb_ext, tx_free;
  logic [LW-1:0] rx_pop_cnt, tx_push_cnt, rx_take;
  logic [31:0]   tx_push_data, rx_peek, tx_peek, rd_pack, rd_data_n;
  logic [CW-1:0] load_val;

  // bus decode
  assign rx_rd  = acc_valid && !acc_write && !acc_sel;
  assign tx_wr  = acc_valid &&  acc_write && !acc_sel;
  assign flush  = acc_valid &&  acc_write &&  acc_sel && acc_wdata[0];
  assign nbytes = width_bytes(acc_width);
  assign nb_ext = (PW+1)'(nbytes);

  // card handshake
  assign card_rx_ready = active && !dir_q && !cnt_zero && (rx_level < (PW+1)'(DEPTH));
  assign card_tx_valid = active &&  dir_q && !cnt_zero && (tx_level != '0);
  assign card_tx_data  = tx_peek[7:0];
  assign rx_fire       = card_rx_valid && card_rx_ready;
  assign tx_fire       = card_tx_valid && card_tx_ready;

  // transmit unpacking: lane N-1 first
  assign tx_free     = (PW+1)'(DEPTH) - tx_level;
  assign tx_push_cnt = !tx_wr ? '0 : (nb_ext > tx_free) ? LW'(tx_free) : LW'(nbytes);

  always_comb begin
    logic [1:0]  lane;
    logic [31:0] shv;
    tx_push_data = '0;
    for (int i = 0; i < BUS_LANES; i++) begin
      lane = 2'(int'(nbytes) - 1 - i);
      shv  = acc_wdata >> {lane, 3'b000};
      if (i < int'(nbytes)) tx_push_data[8*i +: 8] = shv[7:0];
    end
  end

  // receive packing: first byte into lane N-1, unfilled lanes zero
  assign rx_take    = (nb_ext > rx_level) ? LW'(rx_level) : LW'(nbytes);
  assign rx_pop_cnt = rx_rd ? rx_take : '0;

  always_comb begin
    logic [1:0] lane;
    rd_pack = '0;
    for (int i = 0; i < BUS_LANES; i++) begin
      lane = 2'(int'(nbytes) - 1 - i);
      if (LW'(i) < rx_take) rd_pack = rd_pack | (32'(rx_peek[8*i +: 8]) << {lane, 3'b000});
    end
  end

  assign rd_data_n = rx_rd ? rd_pack : rd_data;

  // transfer control
  assign load_val = CW'(blk_cnt) * CW'(blk_len);
  assign finish   = active && cnt_zero && !xfer_start && !clk_stop;

  always_comb begin
    active_n    = active;
    dir_n       = dir_q;
    data_done_n = data_done;
    prog_done_n = prog_done;
    if (xfer_start) begin
      active_n    = 1'b1;
      dir_n       = xfer_dir;
      data_done_n = 1'b0;
      prog_done_n = 1'b0;
    end else if (clk_stop) begin
      active_n = 1'b0;
    end else if (finish) begin
      active_n    = 1'b0;
      data_done_n = 1'b1;
      prog_done_n = dir_q;
    end
  end

  always_comb begin
    rx_req_n = rx_req;
    if (rx_fire)     rx_req_n = 1'b1;
    if (rx_rd)       rx_req_n = 1'b0;
    if (xfer_start)  rx_req_n = 1'b0;
    tx_req_n = tx_req;
    if (active && dir_q && !cnt_zero && tx_level == '0) tx_req_n = 1'b1;
    if (tx_wr || xfer_start) tx_req_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      dir_q     <= 1'b0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
      rd_data   <= '0;
    end else begin
      active    <= active_n;
      dir_q     <= dir_n;
      data_done <= data_done_n;
      prog_done <= prog_done_n;
      rx_req    <= rx_req_n;
      tx_req    <= tx_req_n;
      rd_data   <= rd_data_n;
    end
  end

  cds_byte_counter #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(load_val),
    .dec(rx_fire || tx_fire), .left(bytes_left), .zero(cnt_zero)
  );

  cds_byte_fifo #(.DEPTH(DEPTH), .LANES(BUS_LANES)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(xfer_start),
    .push_cnt(LW'(rx_fire)), .push_data({24'h0, card_rx_data}),
    .pop_cnt(rx_pop_cnt), .level(rx_level), .peek(rx_peek)
  );

  cds_byte_fifo #(.DEPTH(DEPTH), .LANES(BUS_LANES)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(xfer_start || flush),
    .push_cnt(tx_push_cnt), .push_data(tx_push_data),
    .pop_cnt(LW'(tx_fire)), .level(tx_level), .peek(tx_peek)
  );

  p_rx_ready_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == (PW+1)'(DEPTH)) |-> !card_rx_ready);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_done) |-> !active);
  p_prog_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> data_done);
  p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && !xfer_start) |=> !active);
endmodule

// File: tb/card_data_stager_test.sv
module card_data_stager_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 0, xfer_dir = 0, clk_stop = 0;
  logic [11:0] blk_len = 0;
  logic [15:0] blk_cnt = 0;
  logic        acc_valid = 0, acc_write = 0, acc_sel = 0;
  logic [1:0]  acc_width = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] rd_data;
  logic        card_rx_valid = 0;
  logic [7:0]  card_rx_data = 0;
  logic        card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0]  card_tx_data;
  logic        active, rx_req, tx_req, data_done, prog_done;
  logic [27:0] bytes_left;
  logic [5:0]  rx_level, tx_level;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  card_data_stager uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
    .blk_len(blk_len), .blk_cnt(blk_cnt), .clk_stop(clk_stop),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_width(acc_width), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
    .active(active), .bytes_left(bytes_left), .rx_level(rx_level),
    .tx_level(tx_level), .rx_req(rx_req), .tx_req(tx_req),
    .data_done(data_done), .prog_done(prog_done)
  );

  // read vectors: {width code, expected rd_data} after 01..0A are queued
  localparam logic [33:0] RD_VEC [5] = '{
    {2'd0, 32'h0000_0001},
    {2'd1, 32'h0000_0203},
    {2'd2, 32'h0405_0607},
    {2'd2, 32'h0809_0A00},
    {2'd1, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic dir, input logic [11:0] len, input logic [15:0] cnt);
    xfer_dir = dir; blk_len = len; blk_cnt = cnt; xfer_start = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic access(input logic wr, input logic sel, input logic [1:0] w, input logic [31:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_width = w; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_sel = 1'b0;
  endtask

  task automatic card_send(input logic [7:0] b);
    while (!card_rx_ready) @(negedge clk);
    card_rx_valid = 1'b1; card_rx_data = b;
    @(posedge clk); @(negedge clk);
    card_rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] exp_tx [6];
    exp_tx = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
    cycles(2);
    // R1 reset state
    chk("R1 active", 32'(active), 0);
    chk("R1 levels", {rx_level, tx_level}, 0);
    chk("R1 flags", {rx_req, tx_req, data_done, prog_done}, 0);
    chk("R1 bytes_left", 32'(bytes_left), 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    cycles(2);

    // R2/R4 receive ten bytes
    start(1'b0, 12'd5, 16'd2);
    chk("R2 load", 32'(bytes_left), 32'd10);
    chk("R2 active", 32'(active), 1);
    for (int i = 1; i <= 10; i++) card_send(8'(i));
    chk("R4 rx_level", 32'(rx_level), 10);
    chk("R4 bytes_left", 32'(bytes_left), 0);
    chk("R4 rx_req", 32'(rx_req), 1);
    cycles(2);
    // R8 receive completion
    chk("R8 rx done", {active, data_done, prog_done}, 32'b010);

    // R5 packing table
    for (int v = 0; v < 5; v++) begin
      access(1'b0, 1'b0, RD_VEC[v][33:32], 32'h0);
      chk($sformatf("R5 read vec %0d", v), rd_data, RD_VEC[v][31:0]);
    end
    chk("R5 rx_req cleared", 32'(rx_req), 0);
    chk("R5 rx empty", 32'(rx_level), 0);

    // R3 full queue and R10 clock stop
    start(1'b0, 12'd40, 16'd1);
    for (int i = 0; i < 32; i++) card_send(8'(i + 16));
    chk("R3 rx_level cap", 32'(rx_level), 32);
    chk("R3 ready low", 32'(card_rx_ready), 0);
    clk_stop = 1'b1; @(posedge clk); @(negedge clk); clk_stop = 1'b0;
    cycles(1);
    chk("R10 inactive", 32'(active), 0);
    chk("R10 rx_level kept", 32'(rx_level), 32);
    chk("R10 bytes_left kept", 32'(bytes_left), 8);
    access(1'b0, 1'b0, 2'd0, 32'h0);
    chk("R10 contents kept", rd_data, 32'h10);

    // R2 zero product
    start(1'b0, 12'd0, 16'd7);
    cycles(2);
    chk("R2 zero product", {active, data_done}, 32'b01);

    // R6/R7 transmit
    start(1'b1, 12'd6, 16'd1);
    cycles(1);
    chk("R7 tx_req empty", 32'(tx_req), 1);
    access(1'b1, 1'b0, 2'd2, 32'hA1B2_C3D4);
    chk("R7 tx_req cleared", 32'(tx_req), 0);
    access(1'b1, 1'b0, 2'd1, 32'h1234_E5F6);
    chk("R6 tx_level", 32'(tx_level), 6);
    chk("R7 head byte", {card_tx_valid, card_tx_data}, {1'b1, 8'hA1});
    card_tx_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk($sformatf("R7 tx byte %0d", i), {card_tx_valid, card_tx_data}, {1'b1, exp_tx[i]});
      @(posedge clk); @(negedge clk);
    end
    card_tx_ready = 1'b0;
    chk("R7 bytes_left", 32'(bytes_left), 0);
    cycles(1);
    chk("R8 tx done", {active, data_done, prog_done}, 32'b011);

    // R6 overflow cap and R9 flush
    start(1'b1, 12'd64, 16'd1);
    for (int i = 0; i < 9; i++) access(1'b1, 1'b0, 2'd2, 32'h0101_0101 * i);
    chk("R6 tx cap", 32'(tx_level), 32);
    access(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFE);
    chk("R9 bit0 clear no effect", 32'(tx_level), 32);
    access(1'b1, 1'b1, 2'd2, 32'h0000_0001);
    chk("R9 flushed", 32'(tx_level), 0);
    cycles(1);
    chk("R9 tx_req after flush", 32'(tx_req), 1);
    access(1'b1, 1'b0, 2'd0, 32'hAAAA_AA77);
    chk("R6 byte write", {tx_level, card_tx_data}, {6'd1, 8'h77});

    finish_run();
  end
endmodule